// File: doc/BRIEF.md
# Buffered I2C Slave Receiver

This block is an I2C-bus slave that only receives. A host processor sets it up through a small parallel register port, then leaves the bus work to the block. The block watches the bus for a START condition and shifts in the address byte. It acknowledges the byte when it carries the programmed 7-bit own address with a write direction. It can also acknowledge the general call address (00h) when that is enabled. Each acknowledged address raises the serial-interrupt flag, pulls the active-low interrupt line and posts a coded status value. The block holds SCL low until the host clears the flag.

Once the host clears the flag, the block collects a whole burst of data bytes into an internal buffer and interrupts only once per burst. The host sets the burst length in a count register. Every byte before the last is acknowledged. The last byte is acknowledged or refused according to the acknowledge-enable bit at that moment, so the host chooses in advance whether the master may go on. A STOP or repeated START while the block is addressed ends the burst early with its own status code. The host reads the stored bytes through an index register and a data register.

The controller walks through six states. IDLE waits for a START. ADDR shifts in the address byte. ADDR_ACK drives the acknowledge bit. DATA shifts in a data byte. DATA_ACK drives the data acknowledge. HOLD stretches SCL while the flag is set. The transitions are:
- any state to IDLE when the interface is disabled, and on a STOP;
- any state to ADDR on a START;
- ADDR to ADDR_ACK on a match, and ADDR to IDLE on a mismatch, both at the SCL fall after the eighth bit;
- ADDR_ACK to HOLD at the SCL fall that ends the acknowledge;
- DATA to DATA_ACK at the SCL fall after the eighth bit;
- DATA_ACK to DATA for a byte before the last, and DATA_ACK to HOLD for the last byte;
- HOLD to DATA when the host clears the flag after an acknowledged burst, and HOLD to IDLE when it clears the flag after a refused last byte.

Top module: `i2c_burst_slave_rx`

## Requirements
- R1: After reset the status register reads F8h, the control register reads 00h, int_n is 1, and neither sda_oe nor scl_oe is asserted.
- R2: While the enable bit (control bit 6) is 0, the block acknowledges no address and the status stays F8h.
- R3: A START followed by the byte {own address, 0} is acknowledged when the acknowledge-enable bit (control bit 7) is 1. The flag (control bit 3) is then set, int_n goes low and the status reads 60h. The own address is in bits 7..1 of the address register.
- R4: An address byte whose upper seven bits differ from the own address, or whose direction bit is 1, is not acknowledged and raises no interrupt.
- R5: With the acknowledge-enable bit at 0, the own address is not acknowledged.
- R6: When address-register bit 0 is 1, the address byte 00h is acknowledged whatever the acknowledge-enable bit is, and the status reads D0h. When that bit is 0, 00h is not acknowledged.
- R7: While the flag is set after an address or a completed burst, scl_oe holds SCL low. Writing the control register with bit 3 at 0 clears the flag, releases SCL and returns int_n to 1 in the same step.
- R8: After the address flag is cleared, data bytes are stored at buffer indexes 0, 1, 2 and so on, and every byte before the last of the burst is acknowledged.
- R9: On the last byte of a burst the acknowledge equals the acknowledge-enable bit at that moment. The flag is then set with status 80h after an acknowledge or 88h after a refusal. Clearing the flag after a refusal leaves the block unaddressed, so a following STOP raises nothing.
- R10: The burst length is taken from count-register bits 6..0. The value 0 acts as 1, and a value above the buffer depth (68) acts as 68. With the mode bit (control bit 0) at 0, every burst is one byte.
- R11: A STOP while addressed sets the flag with status A0h and returns the block to IDLE.
- R12: Reading register 5 returns the number of bytes stored in the current burst. Writing register 5 selects a buffer index, and reading register 4 returns the byte stored there. Register selects are 0 status, 1 control, 2 address, 3 count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 3 | Register select |
| host_wr | input | 1 | Register write strobe |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data for host_sel (combinational) |
| int_n | output | 1 | Active-low interrupt, low while the flag is set |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (acknowledge) |

## Verification
Two things meet on the same SCL fall at the end of a burst. One is the storage of the final byte and the advance of the byte index. The other is the comparison against the programmed count, which picks between acknowledging the byte and ending the burst on the host's acknowledge choice. A wrong comparison by one acknowledges or ends the burst at the wrong byte. The bench provokes this meeting with bursts of 1 and 68 bytes, with clamped count values, and with the acknowledge-enable bit cleared in the very write that releases the address interrupt. It judges the result by the acknowledge seen on the bus for every byte, by the 80h or 88h status, by the stored-byte count, and by the buffer contents read back.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_HOLD
    } srx_state_t;

    localparam logic [7:0] STAT_IDLE       = 8'hF8;
    localparam logic [7:0] STAT_OWN_WRITE  = 8'h60;
    localparam logic [7:0] STAT_GEN_CALL   = 8'hD0;
    localparam logic [7:0] STAT_BURST_ACK  = 8'h80;
    localparam logic [7:0] STAT_BURST_NACK = 8'h88;
    localparam logic [7:0] STAT_STOP       = 8'hA0;

    localparam logic [2:0] SEL_STATUS = 3'd0;
    localparam logic [2:0] SEL_CTRL   = 3'd1;
    localparam logic [2:0] SEL_ADDR   = 3'd2;
    localparam logic [2:0] SEL_COUNT  = 3'd3;
    localparam logic [2:0] SEL_BUFDAT = 3'd4;
    localparam logic [2:0] SEL_BUFIDX = 3'd5;

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_pin,
    input  logic sda_pin,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_q, sda_q;
    logic scl_d, sda_d, scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[SYNC_STAGES-2:0], scl_pin};
            sda_q <= {sda_q[SYNC_STAGES-2:0], sda_pin};
            scl_d <= scl_q[SYNC_STAGES-1];
            sda_d <= sda_q[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_q[SYNC_STAGES-1];
    assign sda_lvl   = sda_q[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_lvl;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/i2c_srx_buffer.sv
module i2c_srx_buffer #(
    parameter int DEPTH = 68,
    parameter int IDX_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [7:0]       rdata
);
    logic [7:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (we && widx == IDX_W'(g)) mem[g] <= wdata;
        end
    end

    assign rdata = (int'(ridx) < DEPTH) ? mem[ridx] : 8'h00;

    // R12: a store never lands outside the buffer
    a_r12_widx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(widx) < DEPTH));

endmodule

// File: rtl/i2c_srx_fsm.sv
module i2c_srx_fsm
    import i2c_srx_pkg::*;
#(
    parameter int DEPTH = 68,
    parameter int IDX_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             aa,
    input  logic             gc_en,
    input  logic [6:0]       own_addr,
    input  logic [IDX_W-1:0] burst_len,
    input  logic             si_clr,
    input  logic             sda_lvl,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    output logic             si,
    output logic [7:0]       status,
    output logic             sda_oe,
    output logic             scl_oe,
    output logic             buf_we,
    output logic [IDX_W-1:0] buf_widx,
    output logic [7:0]       buf_wdata,
    output logic [IDX_W-1:0] rx_count
);
    srx_state_t state, state_nx;
    logic [6:0]       shreg;
    logic [3:0]       bit_cnt;
    logic [IDX_W-1:0] idx;
    logic             hit, gc_q, last_q, ack_q, end_q;
    logic [7:0]       rx_byte;
    logic             own_hit, gc_hit, addressed;

    assign rx_byte   = {shreg, sda_lvl};
    assign own_hit   = aa && (rx_byte[7:1] == own_addr) && !rx_byte[0];
    assign gc_hit    = gc_en && (rx_byte == 8'h00);
    assign addressed = state inside {ST_ADDR_ACK, ST_DATA, ST_DATA_ACK, ST_HOLD};

    always_comb begin
        state_nx = state;
        if (!en)            state_nx = ST_IDLE;
        else if (start_det) state_nx = ST_ADDR;
        else if (stop_det)  state_nx = ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_ADDR:     if (scl_fall && bit_cnt == 4'd8)
                                 state_nx = hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) state_nx = ST_HOLD;
                ST_DATA:     if (scl_fall && bit_cnt == 4'd8) state_nx = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) state_nx = last_q ? ST_HOLD : ST_DATA;
                ST_HOLD:     if (si_clr) state_nx = end_q ? ST_IDLE : ST_DATA;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            bit_cnt <= '0;
            idx     <= '0;
            hit     <= 1'b0;
            gc_q    <= 1'b0;
            last_q  <= 1'b0;
            ack_q   <= 1'b0;
            end_q   <= 1'b0;
            si      <= 1'b0;
            status  <= STAT_IDLE;
        end else begin
            state <= state_nx;
            if (!en) begin
                si      <= 1'b0;
                status  <= STAT_IDLE;
                bit_cnt <= '0;
            end else begin
                if (si_clr) begin
                    si     <= 1'b0;
                    status <= STAT_IDLE;
                end
                if ((start_det || stop_det) && addressed) begin
                    si     <= 1'b1;
                    status <= STAT_STOP;
                end
                if (start_det) bit_cnt <= '0;
                if (scl_rise && bit_cnt < 4'd8 && (state == ST_ADDR || state == ST_DATA)) begin
                    shreg   <= rx_byte[6:0];
                    bit_cnt <= bit_cnt + 4'd1;
                end
                if (state == ST_ADDR && scl_rise && bit_cnt == 4'd7) begin
                    hit  <= own_hit || gc_hit;
                    gc_q <= gc_hit;
                end
                if (buf_we) idx <= idx + 1'b1;
                if (state == ST_DATA && scl_fall && bit_cnt == 4'd8) begin
                    last_q <= (idx == burst_len);
                    ack_q  <= (idx != burst_len) || aa;
                end
                if (state == ST_DATA_ACK && scl_fall) begin
                    bit_cnt <= '0;
                    if (last_q) begin
                        si     <= 1'b1;
                        status <= ack_q ? STAT_BURST_ACK : STAT_BURST_NACK;
                        end_q  <= !ack_q;
                    end
                end
                if (state == ST_ADDR_ACK && scl_fall) begin
                    si      <= 1'b1;
                    status  <= gc_q ? STAT_GEN_CALL : STAT_OWN_WRITE;
                    end_q   <= 1'b0;
                    bit_cnt <= '0;
                    idx     <= '0;
                end
                if (state == ST_HOLD && si_clr) begin
                    idx     <= '0;
                    bit_cnt <= '0;
                end
            end
        end
    end

    always_comb begin
        sda_oe    = (state == ST_ADDR_ACK) || (state == ST_DATA_ACK && ack_q);
        scl_oe    = (state == ST_HOLD) && si;
        buf_we    = (state == ST_DATA) && scl_rise && (bit_cnt == 4'd7);
        buf_widx  = idx;
        buf_wdata = rx_byte;
        rx_count  = idx;
    end

    // R7: the stretch state is only ever occupied with the flag raised
    a_r7_hold_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> si);

    // R8: bytes before the last of a burst always receive an acknowledge
    a_r8_mid_burst_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA_ACK && !last_q) |-> sda_oe);

    // R11: a bus START or STOP lets go of SDA on the next cycle
    a_r11_bus_event_release: assert property (@(posedge clk) disable iff (!rst_n)
        ((start_det || stop_det) && en) |=> !sda_oe);

endmodule

// File: rtl/i2c_burst_slave_rx.sv
module i2c_burst_slave_rx
    import i2c_srx_pkg::*;
#(
    parameter int BUF_DEPTH   = 68,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] host_sel,
    input  logic       host_wr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       int_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe
);
    localparam int IDX_W = $clog2(BUF_DEPTH + 1);

    logic [7:0]       ctrl_q, adr_q, cnt_q;
    logic [IDX_W-1:0] rd_idx_q, burst_len, buf_widx, rx_count;
    logic [7:0]       buf_wdata, buf_rdata, stat_w;
    logic             si_w, si_clr, buf_we;
    logic             sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [6:0]       req_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            adr_q    <= '0;
            cnt_q    <= '0;
            rd_idx_q <= '0;
        end else if (host_wr) begin
            unique case (host_sel)
                SEL_CTRL:   ctrl_q   <= host_wdata & 8'hF7;
                SEL_ADDR:   adr_q    <= host_wdata;
                SEL_COUNT:  cnt_q    <= host_wdata;
                SEL_BUFIDX: rd_idx_q <= IDX_W'(host_wdata);
                default:    ;
            endcase
        end
    end

    assign si_clr  = host_wr && (host_sel == SEL_CTRL) && !host_wdata[3];
    assign req_len = cnt_q[6:0];

    always_comb begin
        if (!ctrl_q[0] || req_len == 7'd0) burst_len = IDX_W'(1);
        else if (int'(req_len) > BUF_DEPTH) burst_len = IDX_W'(BUF_DEPTH);
        else                                burst_len = IDX_W'(req_len);
    end

    always_comb begin
        unique case (host_sel)
            SEL_STATUS: host_rdata = stat_w;
            SEL_CTRL:   host_rdata = ctrl_q | {4'b0, si_w, 3'b0};
            SEL_ADDR:   host_rdata = adr_q;
            SEL_COUNT:  host_rdata = cnt_q;
            SEL_BUFDAT: host_rdata = buf_rdata;
            SEL_BUFIDX: host_rdata = 8'(rx_count);
            default:    host_rdata = 8'h00;
        endcase
    end

    assign int_n = !si_w;

    i2c_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_pin(scl_in), .sda_pin(sda_in),
        .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_srx_fsm #(.DEPTH(BUF_DEPTH), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(ctrl_q[6]), .aa(ctrl_q[7]),
        .gc_en(adr_q[0]), .own_addr(adr_q[7:1]), .burst_len(burst_len),
        .si_clr(si_clr), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .si(si_w), .status(stat_w), .sda_oe(sda_oe), .scl_oe(scl_oe),
        .buf_we(buf_we), .buf_widx(buf_widx), .buf_wdata(buf_wdata),
        .rx_count(rx_count)
    );

    i2c_srx_buffer #(.DEPTH(BUF_DEPTH), .IDX_W(IDX_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .we(buf_we), .widx(buf_widx),
        .wdata(buf_wdata), .ridx(rd_idx_q), .rdata(buf_rdata)
    );

    // R3: every rise of the flag comes with a coded event status
    a_r3_flag_has_code: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(si_w) |-> (stat_w != STAT_IDLE));

    // R2: a disabled interface drives neither bus line
    a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[6] |=> (!sda_oe && !scl_oe));

endmodule

// File: tb/i2c_burst_slave_rx_tb.sv
module i2c_burst_slave_rx_tb;
    localparam int Q = 12;
    localparam logic [6:0] OWN = 7'h5A;
    // {addr byte, en, aa, gc, exp_ack, 4'b0, exp status}
    localparam logic [23:0] VEC [8] = '{
        24'hB4D060, 24'hB6C0F8, 24'hB5C0F8, 24'h00F0D0,
        24'h00C0F8, 24'hB480F8, 24'hB440F8, 24'h00B0D0
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [2:0] host_sel = '0;
    logic host_wr = 1'b0;
    logic [7:0] host_wdata = '0, host_rdata;
    logic int_n, scl_oe, sda_oe;
    logic scl_m = 1'b1, sda_m = 1'b1;
    wire scl_line = scl_m & ~scl_oe;
    wire sda_line = sda_m & ~sda_oe;
    int checks = 0, fails = 0, cyc = 0;

    always #2 clk = ~clk;

    i2c_burst_slave_rx u_dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .int_n(int_n),
        .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        host_sel = s; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [7:0] v);
        @(negedge clk);
        host_sel = s;
        #1 v = host_rdata;
    endtask

    task automatic m_start();
        sda_m = 1'b1; scl_m = 1'b1; wait_q(Q);
        sda_m = 1'b0; wait_q(Q);
        scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wait_q(Q);
        scl_m = 1'b1; wait (scl_line == 1'b1); wait_q(Q);
        sda_m = 1'b1; wait_q(Q);
    endtask

    task automatic m_bit(input logic b, output logic seen);
        sda_m = b; wait_q(Q);
        scl_m = 1'b1; wait (scl_line == 1'b1); wait_q(Q);
        seen = sda_line; wait_q(Q);
        scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic m_byte(input logic [7:0] d, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) m_bit(d[i], s);
        m_bit(1'b1, s);
        ack = !s;
    endtask

    function automatic logic [7:0] pat(input int k);
        return 8'(k * 37 + 5);
    endfunction

    // Address phase with AA=1, then release the flag with the last-byte choice.
    task automatic open_burst(input logic [7:0] cnt, input logic mode, input logic aa_last);
        logic ack;
        wr(3'd3, cnt);
        wr(3'd2, {OWN, 1'b0});
        wr(3'd1, {2'b11, 5'b0, mode});
        m_start();
        m_byte({OWN, 1'b0}, ack);
        chk("R3 address ack before burst", ack, 1);
        wr(3'd1, {aa_last, 1'b1, 5'b0, mode});
    endtask

    task automatic run_burst(input string tag, input logic [7:0] cnt, input logic mode,
                             input logic aa_last, input int exp_len);
        logic ack;
        logic [7:0] v;
        open_burst(cnt, mode, aa_last);
        for (int k = 0; k < exp_len; k++) begin
            m_byte(pat(k), ack);
            if (k < exp_len - 1) chk({tag, " R8 mid-burst ack"}, ack, 1);
            else                 chk({tag, " R9 last-byte ack"}, ack, aa_last);
        end
        rd(3'd0, v);
        chk({tag, " R9 burst status"}, v, aa_last ? 8'h80 : 8'h88);
        chk({tag, " R7 int low at burst end"}, int_n, 0);
        chk({tag, " R7 scl stretched"}, scl_oe, 1);
        rd(3'd5, v);
        chk({tag, " R12 stored count"}, v, exp_len);
        for (int k = 0; k < exp_len; k++) begin
            wr(3'd5, 8'(k));
            rd(3'd4, v);
            chk({tag, " R8 buffer byte"}, v, pat(k));
        end
        wr(3'd1, 8'hC1);
        chk({tag, " R7 scl released"}, scl_oe, 0);
        m_stop();
        rd(3'd0, v);
        chk({tag, " R11/R9 post-stop status"}, v, aa_last ? 8'hA0 : 8'hF8);
        wr(3'd1, 8'hC1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic ack;
        string tag;
        wait_q(4);
        rst_n = 1'b1;
        wait_q(2);
        // R1: reset state
        rd(3'd0, v); chk("R1 status", v, 8'hF8);
        rd(3'd1, v); chk("R1 ctrl", v, 8'h00);
        chk("R1 int_n", int_n, 1);
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 scl_oe", scl_oe, 0);

        // Address vectors
        for (int i = 0; i < 8; i++) begin
            logic [23:0] e;
            e = VEC[i];
            if (!e[15])                 tag = "R2";
            else if (e[23:16] == 8'h00) tag = "R6";
            else if (!e[14])            tag = "R5";
            else if (e[12])             tag = "R3";
            else                        tag = "R4";
            wr(3'd2, {OWN, e[13]});
            wr(3'd1, {e[14], e[15], 5'b0, 1'b1});
            m_start();
            m_byte(e[23:16], ack);
            chk({tag, " address ack"}, ack, e[12]);
            rd(3'd0, v);
            chk({tag, " address status"}, v, e[7:0]);
            chk({tag, " int_n"}, int_n, !e[12]);
            if (e[12]) begin
                chk("R7 scl held while flag set", scl_line, 0);
                wr(3'd1, {e[14], 7'b1000001});
                chk("R7 int released", int_n, 1);
                chk("R7 scl released", scl_oe, 0);
                m_stop();
                rd(3'd0, v);
                chk("R11 stop while addressed", v, 8'hA0);
                wr(3'd1, 8'hC1);
            end else begin
                m_stop();
                rd(3'd0, v);
                chk({tag, " no event after stop"}, v, 8'hF8);
            end
        end

        // Bursts
        run_burst("len1", 8'd1, 1'b1, 1'b1, 1);
        run_burst("len68", 8'd68, 1'b1, 1'b0, 68);
        run_burst("R10 clamp100", 8'd100, 1'b1, 1'b1, 68);
        run_burst("R10 zero", 8'd0, 1'b1, 1'b0, 1);
        run_burst("R10 mode0", 8'd68, 1'b0, 1'b0, 1);

        // Stop in the middle of a burst
        open_burst(8'd5, 1'b1, 1'b1);
        m_byte(pat(0), ack); chk("R8 stop-test byte0 ack", ack, 1);
        m_byte(pat(1), ack); chk("R8 stop-test byte1 ack", ack, 1);
        m_stop();
        rd(3'd0, v); chk("R11 early stop status", v, 8'hA0);
        chk("R11 early stop int", int_n, 0);
        chk("R11 no stretch after stop", scl_oe, 0);
        rd(3'd5, v); chk("R12 early stop count", v, 2);
        wr(3'd5, 8'd1);
        rd(3'd4, v); chk("R12 early stop byte1", v, pat(1));
        wr(3'd1, 8'hC1);
        chk("R7 flag cleared", int_n, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule